// File: doc/BRIEF.md
# Self-Correcting One-Hot Ring Sequencer

This block is an N-stage shift register that circulates a single 1. It is meant for control sequencing: each stage output is already a decoded state, so a stage can drive a step of a control flow directly, and no decoder that could glitch sits between the register and its users. On every enabled clock edge the contents move one stage up. The first stage does not take the last stage's bit. It takes the NOR of every stage except the last. With this feedback any start-up pattern falls into the legal one-hot rotation by itself, whether that pattern holds several 1s or none at all.

Reset is synchronous and active low, and it places the single 1 in stage 0. The count enable advances the sequence. A test-only seed port writes an arbitrary pattern into the register so that every abnormal state can be reached and its recovery observed. Bit i of the output is stage i.

Top module: `ring_seq`

## Requirements
- R1: On a clock edge with `rst_n` low, `state` becomes only stage 0 set (value 1). Reset takes priority over `seed_we` and `en`.
- R2: On an edge with `rst_n` high and `seed_we` high, `state` takes `seed_val`, whatever the value of `en`.
- R3: On an edge with `rst_n` high, `seed_we` low and `en` low, `state` keeps its value.
- R4: On an enabled edge (`rst_n` high, `seed_we` low, `en` high), stage i+1 takes the old value of stage i, for i from 0 to N-2.
- R5: On an enabled edge, stage 0 takes 1 only when stages 0 to N-2 were all 0. For N=4, 1111 goes to 1110 and 0000 goes to 0001.
- R6: Once `state` is one-hot, each enabled edge moves the 1 from stage i to stage (i+1) mod N. From reset with N=4 the values are 0001, 0010, 0100, 1000, 0001.
- R7: From any of the 2^N patterns, `state` is one-hot after at most N-1 enabled edges, and from then on it follows R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance the sequence by one stage |
| seed_we | input | 1 | Test-only: write `seed_val` into the register |
| seed_val | input | N | Test-only pattern to write |
| state | output | N | Stage outputs, bit i is stage i |

## Verification
The bound checker checks on every cycle the reset value, seeding, holding, the shift of each stage, the feedback into stage 0, and the rule that a one-hot state stays one-hot. It also keeps a counter that bounds how many enabled edges a non-one-hot state may last. The exact rotation order from reset, the specific recovery paths such as 1111 decaying stage by stage, and the visit to all 2^N seeded patterns are scenarios that only the bench drives. The bench checks each of these against values worked out from the requirements.

// File: rtl/ring_seq.sv
module ring_seq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         seed_we,
  input  logic [N-1:0] seed_val,
  output logic [N-1:0] state
);

  localparam logic [N-1:0] HOME = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] q;
  logic         head_in;

  assign head_in = ~|q[N-2:0];
  assign state   = q;

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= HOME;
    else if (seed_we) q <= seed_val;
    else if (en)      q <= {q[N-2:0], head_in};
  end

endmodule

// File: rtl/ring_seq_chk.sv
module ring_seq_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         seed_we,
  input logic [N-1:0] seed_val,
  input logic [N-1:0] state
);

  localparam int CW = $clog2(N) + 2;

  logic [CW-1:0] bad_run;
  logic          adv;

  assign adv = rst_n && !seed_we && en;

  always_ff @(posedge clk) begin
    if (!rst_n || seed_we)            bad_run <= '0;
    else if (en && $countones(state) != 1) bad_run <= bad_run + 1'b1;
    else if (en)                      bad_run <= '0;
  end

  // R1
  reset_val_chk: assert property (@(posedge clk)
    !rst_n |=> state == {{(N-1){1'b0}}, 1'b1});

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |=> state == $past(seed_val));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_we && !en) |=> $stable(state));

  // R4
  stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> state[N-1:1] == $past(state[N-2:0]));

  // R5
  head_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> state[0] == ($past(state[N-2:0]) == '0));

  // R6
  onehot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && $countones(state) == 1) |=> $countones(state) == 1);

  // R7
  recover_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_run <= CW'(N - 1));

endmodule

bind ring_seq ring_seq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .seed_we(seed_we),
  .seed_val(seed_val), .state(state)
);

// File: tb/tb_ring_seq.sv
module tb_ring_seq;
  localparam int N = 4;
  localparam int K_EXACT = 0, K_ONEHOT = 1, K_FOLLOW = 2, K_SKIP = 3;

  typedef struct {
    logic [N-1:0] val;
    int           kind;
    string        req;
  } item_t;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         en = 0;
  logic         seed_we = 0;
  logic [N-1:0] seed_val = '0;
  logic [N-1:0] state;

  int checks = 0;
  int errors = 0;
  item_t sb[$];
  logic [N-1:0] last = '0;

  always #5 clk = ~clk;

  ring_seq #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .seed_we(seed_we),
    .seed_val(seed_val), .state(state)
  );

  task automatic step(input logic r, input logic w, input logic e,
                      input logic [N-1:0] sv, input int kind,
                      input logic [N-1:0] val, input string req);
    item_t it;
    @(negedge clk);
    rst_n = r; seed_we = w; en = e; seed_val = sv;
    it.val = val; it.kind = kind; it.req = req;
    sb.push_back(it);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      item_t it;
      logic [N-1:0] exp;
      it = sb.pop_front();
      if (it.kind != K_SKIP) begin
        checks++;
        case (it.kind)
          K_EXACT: exp = it.val;
          K_FOLLOW: exp = {last[N-2:0], last[N-1]};
          default: exp = state;
        endcase
        if (it.kind == K_ONEHOT) begin
          if ($countones(state) != 1) begin
            errors++;
            $display("FAIL %s: state %b not one-hot", it.req, state);
          end
        end else if (state !== exp) begin
          errors++;
          $display("FAIL %s: state %b expected %b", it.req, state, exp);
        end
      end
    end
    last = state;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset
    step(0, 0, 0, '0, K_EXACT, 4'b0001, "R1");
    // R6 legal order from reset
    step(1, 0, 1, '0, K_EXACT, 4'b0010, "R6");
    step(1, 0, 1, '0, K_EXACT, 4'b0100, "R6");
    step(1, 0, 1, '0, K_EXACT, 4'b1000, "R6");
    step(1, 0, 1, '0, K_EXACT, 4'b0001, "R6");
    step(1, 0, 1, '0, K_EXACT, 4'b0010, "R6");
    // R3 hold
    step(1, 0, 0, 4'b1111, K_EXACT, 4'b0010, "R3");
    step(1, 0, 0, 4'b1111, K_EXACT, 4'b0010, "R3");
    // R1 priority over seed and enable
    step(0, 1, 1, 4'b1010, K_EXACT, 4'b0001, "R1");
    // R2 seed, then R4/R5 decay of all ones
    step(1, 1, 0, 4'b1111, K_EXACT, 4'b1111, "R2");
    step(1, 0, 1, '0, K_EXACT, 4'b1110, "R4");
    step(1, 0, 1, '0, K_EXACT, 4'b1100, "R5");
    step(1, 0, 1, '0, K_EXACT, 4'b1000, "R4");
    step(1, 0, 1, '0, K_EXACT, 4'b0001, "R5");
    // R5 all zeros
    step(1, 1, 0, 4'b0000, K_EXACT, 4'b0000, "R2");
    step(1, 0, 1, '0, K_EXACT, 4'b0001, "R5");
    // R2 seed wins over enable
    step(1, 1, 1, 4'b0110, K_EXACT, 4'b0110, "R2");
    // R7 every start pattern
    for (int p = 0; p < (1 << N); p++) begin
      step(1, 1, 0, N'(p), K_EXACT, N'(p), "R2");
      for (int k = 1; k < N - 1; k++)
        step(1, 0, 1, '0, K_SKIP, '0, "R7");
      step(1, 0, 1, '0, K_ONEHOT, '0, "R7");
      step(1, 0, 1, '0, K_FOLLOW, '0, "R7");
      step(1, 0, 1, '0, K_FOLLOW, '0, "R6");
    end
    step(1, 0, 0, '0, K_SKIP, '0, "end");
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule